// File: doc/BRIEF.md
# Bufferless Deflection Mesh Router

This block is a five-port router for a two-dimensional mesh of processing elements. Four network ports face the neighbouring routers (north, south, east, west). A fifth, local port lets the attached processing element inject flits into the mesh and receive the flits addressed to it. Every packet is a single flit. The router has no input queues. Every flit that arrives in a cycle is given an output in that same cycle and leaves through a single register stage. When two flits contend for a link, the older one takes it and the other is pushed out through some other free link. Flits are never dropped and never held back.

Each flit carries a destination column and row, an age and a payload. The router compares the destination with its own coordinates, which arrive on input pins. From this it works out the productive directions. It serves flits in age order and hands each one the best link still free. The local element may inject a flit only when a network output is still unclaimed after all arriving flits are placed. The router rewrites the age of every flit it forwards, so that a flit which has travelled longer gains priority over time.

Top module: `defr_router`

## Requirements
- R1: While reset is asserted, and in the first cycles after its release, all four network output valids and the local delivery valid are low.
- R2: Every valid arriving network flit, and every accepted injected flit, appears on exactly one output (a network port or local delivery) at the clock edge that samples it. Nothing is dropped and nothing is duplicated.
- R3: Port index 0 is north, 1 south, 2 east and 3 west. East means a larger column and north means a larger row. A flit that meets no contention leaves east or west if its column differs from the router's. Otherwise it leaves north or south if its row differs. The column direction is preferred over the row direction.
- R4: A flit whose column and row both equal the router's is delivered on the local output. At most one flit is delivered per cycle. Among several such flits the highest-priority one (see R5) is delivered, and the others leave on network ports.
- R5: Flits are served in priority order. A larger age wins. On equal age the lower input port index wins. The injected flit is always served last.
- R6: A flit whose column direction is already taken takes its row direction if that is productive and free. Otherwise it takes the free network port with the lowest index.
- R7: inj_ready is high in a cycle exactly when at least one network output is unclaimed after all arriving network flits are placed. An injected flit is accepted only when inj_vld and inj_ready are both high.
- R8: An accepted injected flit is placed after all network flits by the rule of R3/R6. Its supplied age is replaced by zero before forwarding.
- R9: The flit layout is payload in bits 7:0, destination column in bits 10:8, destination row in bits 13:11, and age in bits 17:14. A flit leaving on a network port carries its age plus one, saturating at 15. A locally delivered flit keeps its age unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_x | input | 3 | Column of this router |
| my_y | input | 3 | Row of this router |
| in_vld | input | 4 | Arriving flit valid per network port (0 N, 1 S, 2 E, 3 W) |
| in_data | input | 72 | Arriving flits, port p in bits 18p+17:18p |
| inj_vld | input | 1 | Local element offers a flit |
| inj_data | input | 18 | Offered flit |
| inj_ready | output | 1 | A network output is free this cycle; the offer is taken |
| out_vld | output | 4 | Departing flit valid per network port |
| out_data | output | 72 | Departing flits, port p in bits 18p+17:18p |
| ej_vld | output | 1 | Flit delivered to the local element |
| ej_data | output | 18 | Delivered flit |

## Verification
A wrong priority ranking or a stale free-port mask does not lose flits silently. It shows up one clock after the stimulus, as a payload on the wrong output port, a missing or doubled valid, or an inj_ready that disagrees with the count of arriving flits. The count of flits in against flits out, one cycle apart, catches any allocation that drops or duplicates a flit in the very cycle it happens. Directed contention cases with chosen ages and tie patterns check the winner and the deflection target port by port. A fault in the age update shows in the age field of the next departing flit.

// File: rtl/defr_pkg.sv
package defr_pkg;
  localparam int COORD_W = 3;
  localparam int AGE_W   = 4;
  localparam int PAY_W   = 8;
  localparam int NET_P   = 4;
  localparam int FLIT_W  = AGE_W + 2 * COORD_W + PAY_W;
  localparam int RANK_W  = $clog2(NET_P);
  localparam int SRC_W   = $clog2(NET_P + 1);

  localparam int P_N = 0;
  localparam int P_S = 1;
  localparam int P_E = 2;
  localparam int P_W = 3;

  typedef struct packed {
    logic [AGE_W-1:0]   age;
    logic [COORD_W-1:0] dy;
    logic [COORD_W-1:0] dx;
    logic [PAY_W-1:0]   pay;
  } flit_t;

  function automatic logic [AGE_W-1:0] age_bump(input logic [AGE_W-1:0] a);
    return (a == '1) ? a : a + 1'b1;
  endfunction
endpackage

// File: rtl/defr_rst_sync.sv
module defr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/defr_prod_dir.sv
module defr_prod_dir
  import defr_pkg::*;
(
  input  logic [COORD_W-1:0] my_x,
  input  logic [COORD_W-1:0] my_y,
  input  logic [COORD_W-1:0] dx,
  input  logic [COORD_W-1:0] dy,
  output logic [NET_P-1:0]   x_pref,
  output logic [NET_P-1:0]   y_pref,
  output logic               home
);
  always_comb begin
    x_pref = '0;
    y_pref = '0;
    if (dx > my_x)      x_pref[P_E] = 1'b1;
    else if (dx < my_x) x_pref[P_W] = 1'b1;
    if (dy > my_y)      y_pref[P_N] = 1'b1;
    else if (dy < my_y) y_pref[P_S] = 1'b1;
    home = (dx == my_x) && (dy == my_y);
  end
endmodule

// File: rtl/defr_rank.sv
module defr_rank
  import defr_pkg::*;
(
  input  logic [NET_P-1:0]            vld,
  input  logic [NET_P-1:0][AGE_W-1:0] age,
  output logic [NET_P-1:0][RANK_W-1:0] rank
);
  always_comb begin
    rank = '0;
    for (int i = 0; i < NET_P; i++) begin
      for (int j = 0; j < NET_P; j++) begin
        if (j != i && vld[j] &&
            ((age[j] > age[i]) || ((age[j] == age[i]) && (j < i)))) begin
          rank[i] = rank[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/defr_alloc.sv
module defr_alloc
  import defr_pkg::*;
(
  input  logic [NET_P-1:0]             vld,
  input  logic [NET_P-1:0][RANK_W-1:0] rank,
  input  logic [NET_P-1:0][NET_P-1:0]  x_pref,
  input  logic [NET_P-1:0][NET_P-1:0]  y_pref,
  input  logic [NET_P-1:0]             home,
  input  logic                         inj_vld,
  input  logic [NET_P-1:0]             inj_x_pref,
  input  logic [NET_P-1:0]             inj_y_pref,
  output logic [NET_P-1:0]             out_take,
  output logic [NET_P-1:0][SRC_W-1:0]  out_sel,
  output logic                         ej_take,
  output logic [RANK_W-1:0]            ej_sel,
  output logic                         inj_ready
);
  logic [NET_P-1:0] free;
  logic [NET_P-1:0] want;
  logic [NET_P-1:0] pick;
  logic             ej_free;

  always_comb begin
    free     = '1;
    ej_free  = 1'b1;
    ej_take  = 1'b0;
    ej_sel   = '0;
    out_take = '0;
    out_sel  = '0;
    want     = '0;
    pick     = '0;
    for (int r = 0; r < NET_P; r++) begin
      for (int i = 0; i < NET_P; i++) begin
        if (vld[i] && (rank[i] == RANK_W'(r))) begin
          if (home[i] && ej_free) begin
            ej_free = 1'b0;
            ej_take = 1'b1;
            ej_sel  = RANK_W'(i);
          end else begin
            want = x_pref[i] & free;
            if (want == '0) want = y_pref[i] & free;
            if (want == '0) want = free;
            pick = want & (~want + 1'b1);
            free = free & ~pick;
            for (int o = 0; o < NET_P; o++) begin
              if (pick[o]) begin
                out_take[o] = 1'b1;
                out_sel[o]  = SRC_W'(i);
              end
            end
          end
        end
      end
    end
    inj_ready = |free;
    if (inj_vld && inj_ready) begin
      want = inj_x_pref & free;
      if (want == '0) want = inj_y_pref & free;
      if (want == '0) want = free;
      pick = want & (~want + 1'b1);
      for (int o = 0; o < NET_P; o++) begin
        if (pick[o]) begin
          out_take[o] = 1'b1;
          out_sel[o]  = SRC_W'(NET_P);
        end
      end
    end
  end
endmodule

// File: rtl/defr_router.sv
module defr_router
  import defr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [COORD_W-1:0]        my_x,
  input  logic [COORD_W-1:0]        my_y,
  input  logic [NET_P-1:0]          in_vld,
  input  logic [NET_P*FLIT_W-1:0]   in_data,
  input  logic                      inj_vld,
  input  logic [FLIT_W-1:0]         inj_data,
  output logic                      inj_ready,
  output logic [NET_P-1:0]          out_vld,
  output logic [NET_P*FLIT_W-1:0]   out_data,
  output logic                      ej_vld,
  output logic [FLIT_W-1:0]         ej_data
);
  logic                         rst_n_s;
  flit_t [NET_P-1:0]            in_f;
  flit_t                        inj_f;
  logic [NET_P-1:0][AGE_W-1:0]  in_age;
  logic [NET_P-1:0][NET_P-1:0]  x_pref;
  logic [NET_P-1:0][NET_P-1:0]  y_pref;
  logic [NET_P-1:0]             home;
  logic [NET_P-1:0]             inj_x_pref;
  logic [NET_P-1:0]             inj_y_pref;
  logic                         inj_home;
  logic [NET_P-1:0][RANK_W-1:0] rank;
  logic [NET_P-1:0]             out_take;
  logic [NET_P-1:0][SRC_W-1:0]  out_sel;
  logic                         ej_take;
  logic [RANK_W-1:0]            ej_sel;
  flit_t [NET_P-1:0]            out_nxt;
  flit_t                        ej_nxt;
  flit_t [NET_P-1:0]            out_q;
  flit_t                        ej_q;
  logic [NET_P-1:0]             out_vld_q;
  logic                         ej_vld_q;

  defr_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign in_f  = in_data;
  assign inj_f = inj_data;

  for (genvar g = 0; g < NET_P; g++) begin : g_dir
    assign in_age[g] = in_f[g].age;
    defr_prod_dir dir_i (
      .my_x   (my_x),
      .my_y   (my_y),
      .dx     (in_f[g].dx),
      .dy     (in_f[g].dy),
      .x_pref (x_pref[g]),
      .y_pref (y_pref[g]),
      .home   (home[g])
    );
  end

  defr_prod_dir inj_dir_i (
    .my_x   (my_x),
    .my_y   (my_y),
    .dx     (inj_f.dx),
    .dy     (inj_f.dy),
    .x_pref (inj_x_pref),
    .y_pref (inj_y_pref),
    .home   (inj_home)
  );

  defr_rank rank_i (
    .vld  (in_vld),
    .age  (in_age),
    .rank (rank)
  );

  defr_alloc alloc_i (
    .vld        (in_vld),
    .rank       (rank),
    .x_pref     (x_pref),
    .y_pref     (y_pref),
    .home       (home),
    .inj_vld    (inj_vld),
    .inj_x_pref (inj_x_pref),
    .inj_y_pref (inj_y_pref),
    .out_take   (out_take),
    .out_sel    (out_sel),
    .ej_take    (ej_take),
    .ej_sel     (ej_sel),
    .inj_ready  (inj_ready)
  );

  // Next-state datapath: select source, refresh age
  always_comb begin
    for (int o = 0; o < NET_P; o++) begin
      if (out_sel[o] == SRC_W'(NET_P)) begin
        out_nxt[o]     = inj_f;
        out_nxt[o].age = AGE_W'(1);
      end else begin
        out_nxt[o]     = in_f[out_sel[o][RANK_W-1:0]];
        out_nxt[o].age = age_bump(in_f[out_sel[o][RANK_W-1:0]].age);
      end
    end
    ej_nxt = in_f[ej_sel];
  end

  // Valid registers with reset
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_vld_q <= '0;
      ej_vld_q  <= 1'b0;
    end else begin
      out_vld_q <= out_take;
      ej_vld_q  <= ej_take;
    end
  end

  // Data registers, loaded only when a flit is placed
  always_ff @(posedge clk) begin
    for (int o = 0; o < NET_P; o++) begin
      if (out_take[o]) out_q[o] <= out_nxt[o];
    end
    if (ej_take) ej_q <= ej_nxt;
  end

  assign out_vld  = out_vld_q;
  assign out_data = out_q;
  assign ej_vld   = ej_vld_q;
  assign ej_data  = ej_q;

  logic unused_ok;
  assign unused_ok = inj_home ^ (^inj_f.age);
endmodule

// File: rtl/defr_chk.sv
module defr_chk
  import defr_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic [COORD_W-1:0]      my_x,
  input logic [COORD_W-1:0]      my_y,
  input logic [NET_P-1:0]        in_vld,
  input logic [NET_P*FLIT_W-1:0] in_data,
  input logic                    inj_vld,
  input logic [FLIT_W-1:0]       inj_data,
  input logic                    inj_ready,
  input logic [NET_P-1:0]        out_vld,
  input logic [NET_P*FLIT_W-1:0] out_data,
  input logic                    ej_vld,
  input logic [FLIT_W-1:0]       ej_data
);
  flit_t [NET_P-1:0] in_f;
  flit_t [NET_P-1:0] out_f;
  flit_t             ej_f;
  logic  [NET_P-1:0] in_home;
  logic              live;

  assign in_f  = in_data;
  assign out_f = out_data;
  assign ej_f  = ej_data;

  always_comb begin
    for (int i = 0; i < NET_P; i++) begin
      in_home[i] = in_vld[i] && (in_f[i].dx == my_x) && (in_f[i].dy == my_y);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  AST_FLIT_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> ($countones(out_vld) + $countones(ej_vld)) ==
             ($past($countones(in_vld)) + $past($countones(inj_vld && inj_ready)))); // R2

  AST_EJECT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ej_vld) |-> (ej_f.dx == $past(my_x)) && (ej_f.dy == $past(my_y))); // R4

  AST_EJECT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(in_home != '0)) |-> ej_vld); // R4

  AST_INJ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(in_vld) < NET_P) |-> inj_ready); // R7

  AST_INJ_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld == '1 && in_home == '0) |-> !inj_ready); // R7

  for (genvar o = 0; o < NET_P; o++) begin : g_age
    AST_AGE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[o] |-> out_f[o].age != '0); // R9
  end

  logic unused_ok;
  assign unused_ok = ^inj_data ^ ej_f.pay[0] ^ ej_f.age[0];
endmodule

bind defr_router defr_chk chk_i (.*);

// File: tb/defr_router_tb_top.sv
module defr_router_tb_top;
  import defr_pkg::*;

  logic                    clk;
  logic                    rst_n;
  logic [COORD_W-1:0]      my_x;
  logic [COORD_W-1:0]      my_y;
  logic [NET_P-1:0]        in_vld;
  logic [NET_P*FLIT_W-1:0] in_data;
  logic                    inj_vld;
  logic [FLIT_W-1:0]       inj_data;
  logic                    inj_ready;
  logic [NET_P-1:0]        out_vld;
  logic [NET_P*FLIT_W-1:0] out_data;
  logic                    ej_vld;
  logic [FLIT_W-1:0]       ej_data;

  int total = 0;
  int bad   = 0;
  logic rdy_seen;

  defr_router dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic flit_t mk(input int age, input int x, input int y, input int pay);
    flit_t f;
    f.age = AGE_W'(age);
    f.dx  = COORD_W'(x);
    f.dy  = COORD_W'(y);
    f.pay = PAY_W'(pay);
    return f;
  endfunction

  task automatic put(input int p, input flit_t f);
    in_vld[p] = 1'b1;
    in_data[p*FLIT_W +: FLIT_W] = f;
  endtask

  task automatic clear_in();
    in_vld   = '0;
    in_data  = '0;
    inj_vld  = 1'b0;
    inj_data = '0;
  endtask

  // inputs already placed; sample ready, clock once, look after the edge
  task automatic step();
    #1 rdy_seen = inj_ready;
    @(posedge clk);
    #1 clear_in();
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_port(input string req, input int p, input int pay, input int age);
    flit_t f;
    f = out_data[p*FLIT_W +: FLIT_W];
    check(req, $sformatf("port%0d valid", p), int'(out_vld[p]), 1);
    check(req, $sformatf("port%0d payload", p), int'(f.pay), pay);
    check(req, $sformatf("port%0d age", p), int'(f.age), age);
  endtask

  task automatic chk_ej(input string req, input int pay, input int age);
    flit_t f;
    f = ej_data;
    check(req, "eject valid", int'(ej_vld), 1);
    check(req, "eject payload", int'(f.pay), pay);
    check(req, "eject age", int'(f.age), age);
  endtask

  task automatic t_reset();
    check("R1", "out_vld in reset", int'(out_vld), 0);
    check("R1", "ej_vld in reset", int'(ej_vld), 0);
  endtask

  task automatic t_lone();
    @(negedge clk); put(P_W, mk(2, 5, 2, 8'hA1)); step();
    chk_port("R3", P_E, 8'hA1, 3);
    check("R2", "only east valid", int'(out_vld), 4'b0100);
    @(negedge clk); put(P_N, mk(0, 2, 0, 8'hA2)); step();
    chk_port("R3", P_S, 8'hA2, 1);
    @(negedge clk); put(P_E, mk(0, 4, 6, 8'hA3)); step();
    chk_port("R3", P_E, 8'hA3, 1);
    check("R3", "column before row", int'(out_vld), 4'b0100);
    @(negedge clk); put(P_S, mk(0, 0, 5, 8'hA4)); step();
    chk_port("R3", P_W, 8'hA4, 1);
  endtask

  task automatic t_eject();
    @(negedge clk); put(P_N, mk(7, 2, 2, 8'hB1)); step();
    chk_ej("R9", 8'hB1, 7);
    check("R4", "no network output", int'(out_vld), 0);
  endtask

  task automatic t_age_win();
    @(negedge clk); put(P_N, mk(3, 5, 2, 8'hC1)); put(P_S, mk(5, 5, 2, 8'hC2)); step();
    chk_port("R5", P_E, 8'hC2, 6);
    chk_port("R6", P_N, 8'hC1, 4);
  endtask

  task automatic t_tie();
    @(negedge clk); put(P_N, mk(3, 5, 2, 8'hC3)); put(P_S, mk(3, 5, 2, 8'hC4)); step();
    chk_port("R5", P_E, 8'hC3, 4);
    chk_port("R6", P_N, 8'hC4, 4);
  endtask

  task automatic t_row_fallback();
    @(negedge clk); put(P_S, mk(1, 5, 0, 8'hD1)); put(P_W, mk(4, 5, 2, 8'hD2)); step();
    chk_port("R5", P_E, 8'hD2, 5);
    chk_port("R6", P_S, 8'hD1, 2);
    check("R6", "two outputs only", int'(out_vld), 4'b0110);
  endtask

  task automatic t_two_home();
    @(negedge clk); put(P_E, mk(2, 2, 2, 8'hE1)); put(P_W, mk(2, 2, 2, 8'hE2)); step();
    chk_ej("R4", 8'hE1, 2);
    chk_port("R4", P_N, 8'hE2, 3);
    @(negedge clk); put(P_E, mk(1, 2, 2, 8'hE3)); put(P_W, mk(6, 2, 2, 8'hE4)); step();
    chk_ej("R4", 8'hE4, 6);
    chk_port("R5", P_N, 8'hE3, 2);
  endtask

  task automatic t_inj_alone();
    @(negedge clk); inj_vld = 1'b1; inj_data = mk(9, 0, 2, 8'hF1); step();
    check("R7", "ready with idle inputs", int'(rdy_seen), 1);
    chk_port("R8", P_W, 8'hF1, 1);
  endtask

  task automatic t_inj_full();
    @(negedge clk);
    for (int p = 0; p < NET_P; p++) put(p, mk(0, 5, 2, 8'h10 + p));
    inj_vld = 1'b1; inj_data = mk(0, 0, 2, 8'hFF); step();
    check("R7", "ready with four flits", int'(rdy_seen), 0);
    chk_port("R2", P_E, 8'h10, 1);
    chk_port("R2", P_N, 8'h11, 1);
    chk_port("R2", P_S, 8'h12, 1);
    chk_port("R7", P_W, 8'h13, 1);
    check("R7", "no delivery", int'(ej_vld), 0);
  endtask

  task automatic t_inj_three();
    @(negedge clk);
    for (int p = 0; p < 3; p++) put(p, mk(0, 5, 2, 8'h20 + p));
    inj_vld = 1'b1; inj_data = mk(3, 2, 0, 8'h23); step();
    check("R7", "ready with three flits", int'(rdy_seen), 1);
    chk_port("R8", P_E, 8'h20, 1);
    chk_port("R8", P_N, 8'h21, 1);
    chk_port("R8", P_S, 8'h22, 1);
    chk_port("R8", P_W, 8'h23, 1);
  endtask

  task automatic t_inj_home_slot();
    @(negedge clk);
    put(P_N, mk(0, 2, 2, 8'h30));
    put(P_S, mk(0, 5, 2, 8'h31));
    put(P_E, mk(0, 5, 2, 8'h32));
    put(P_W, mk(0, 5, 2, 8'h33));
    inj_vld = 1'b1; inj_data = mk(0, 2, 5, 8'h34); step();
    check("R7", "ready after delivery frees a port", int'(rdy_seen), 1);
    chk_ej("R4", 8'h30, 0);
    chk_port("R7", P_E, 8'h31, 1);
    chk_port("R7", P_N, 8'h32, 1);
    chk_port("R7", P_S, 8'h33, 1);
    chk_port("R8", P_W, 8'h34, 1);
  endtask

  task automatic t_saturate();
    @(negedge clk); put(P_W, mk(15, 5, 2, 8'h40)); step();
    chk_port("R9", P_E, 8'h40, 15);
    @(negedge clk); step();
    check("R2", "idle cycle empty", int'(out_vld), 0);
    check("R2", "idle cycle no delivery", int'(ej_vld), 0);
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    my_x  = 3'd2;
    my_y  = 3'd2;
    clear_in();
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 t_reset();
    repeat (3) @(posedge clk);
    t_lone();
    t_eject();
    t_age_win();
    t_tie();
    t_row_fallback();
    t_two_home();
    t_inj_alone();
    t_inj_full();
    t_inj_three();
    t_inj_home_slot();
    t_saturate();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule